// File: doc/BRIEF.md
# System Management Mode Sequencer

This block is the control sequencer that takes a processor core into and out of its system management mode. It watches a system-management interrupt (SMI) request together with a debug-exception request and an external interrupt request. At each instruction boundary, or while the core sits halted, it picks the winner. When the SMI is taken, the block first holds off until the store path is empty. It then raises the SMM-active indication and starts the state-save engine through a request/done handshake. The handler then runs with ordinary interrupts blocked.

The resume instruction is decoded elsewhere and arrives as a strobe. When that strobe comes inside SMM, the sequencer starts the restore engine. It then judges the values the engine hands back. A bad base or a forbidden control-register bit pair sends the core into shutdown. Otherwise the block returns to the interrupted operating mode, loads the new save-area base, and reports whether the halt or the trapped I/O instruction must run again. The block holds one SMI that arrives during a session and replays it once the session has ended. When the resume strobe comes outside SMM, the block reports an invalid opcode.

Top module: `smm_sequencer`

## Requirements
- R1: In the RUN state at a boundary (`insn_boundary` or `cpu_halted` high), a pending SMI (`smi_req` or the held latch) is taken (`take_smi`), and it suppresses `take_dbg` and `take_irq`. With no SMI, a debug request wins over an external interrupt. No request is taken outside RUN.
- R2: After an SMI is taken, `smiact` rises only in the cycle after one where `stores_pending` is 0, `wbuf_empty` is 1, and either `wr_inflight` is 0 or `rdy` or `brdy` is 1.
- R3: `irq_block` is high from the cycle after the SMI is taken until the restore handshake ends. No debug or external request is taken while it is high.
- R4: Any `smi_req` that is not consumed in the same cycle sets the one-deep `smi_pending` latch. Further requests while it is set are dropped. The held request is taken at the first boundary after the session's successful resume.
- R5: A resume strobe (`rsm_exec` with `insn_boundary`) in RUN pulses `invalid_opcode` in the same cycle and leaves the state unchanged. An SMI taken in that same cycle suppresses the pulse.
- R6: When `restore_done` arrives, the session ends in shutdown if `rs_base[14:0]` is nonzero, if `rs_pg`=1 with `rs_pe`=0, or if `rs_nw`=1 with `rs_cd`=0. `shutdown` rises in the next cycle and `smiact` falls.
- R7: `shutdown_cycle` is high for exactly the first cycle of shutdown. `shutdown` stays high until `nmi` is sampled high, and the sequencer then returns to RUN.
- R8: On a successful resume, `redo_halt` pulses with `resume_valid` only if the core was halted when the SMI was taken and `rs_halt_slot` is 1.
- R9: On a successful resume, `redo_io` pulses with `resume_valid` exactly when `rs_io_slot` is 1.
- R10: `smm_base` takes the value of `rs_base` on a successful resume (visible with `resume_valid`). It changes at no other time except reset.
- R11: After reset, `smm_base` is 0x0003_0000, `smi_pending` and `smiact` are 0, `resume_mode` is 0 (real mode), and no request strobes are active. Reset also ends a session in progress.
- R12: `save_req` is held from the `smiact` rise until `save_done`. `restore_req` is held from the cycle after the in-SMM resume strobe until `restore_done`.
- R13: `smiact` stays high from the first save cycle until the restore handshake completes. On a successful resume, `resume_mode` takes the `cur_mode` value sampled when the SMI was taken (0 real, 1 protected, 2 virtual).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| cpu_halted | input | 1 | Core is in the halt state |
| cur_mode | input | 2 | Current operating mode: 0 real, 1 protected, 2 virtual |
| smi_req | input | 1 | SMI request pulse |
| dbg_req | input | 1 | Debug exception request |
| ext_irq_req | input | 1 | External interrupt request |
| nmi | input | 1 | Non-maskable interrupt |
| rsm_exec | input | 1 | Resume instruction decoded |
| stores_pending | input | 1 | Stores still outstanding in the core |
| wbuf_empty | input | 1 | Write buffer empty |
| wr_inflight | input | 1 | Last bus write still awaiting completion |
| rdy | input | 1 | Bus ready |
| brdy | input | 1 | Burst ready |
| save_done | input | 1 | Save engine finished |
| restore_done | input | 1 | Restore engine finished; rs_* valid |
| rs_base | input | 32 | Restored relocation slot |
| rs_pg | input | 1 | Restored paging-enable bit |
| rs_pe | input | 1 | Restored protection-enable bit |
| rs_nw | input | 1 | Restored not-write-through bit |
| rs_cd | input | 1 | Restored cache-disable bit |
| rs_halt_slot | input | 1 | Restored halt-restart slot |
| rs_io_slot | input | 1 | Restored I/O-trap-restart slot |
| take_smi | output | 1 | SMI accepted this cycle |
| take_dbg | output | 1 | Debug exception accepted this cycle |
| take_irq | output | 1 | External interrupt accepted this cycle |
| invalid_opcode | output | 1 | Resume strobe outside SMM |
| irq_block | output | 1 | Ordinary interrupts blocked |
| smiact | output | 1 | SMM active |
| save_req | output | 1 | Save engine request |
| restore_req | output | 1 | Restore engine request |
| smi_pending | output | 1 | One-deep held SMI |
| smm_base | output | 32 | Active save-area base |
| shutdown | output | 1 | Shutdown state, no instruction issue |
| shutdown_cycle | output | 1 | One-cycle shutdown bus cycle indication |
| resume_valid | output | 1 | Successful resume pulse |
| resume_mode | output | 2 | Mode returned to on the last resume |
| redo_halt | output | 1 | Re-execute the HALT instruction |
| redo_io | output | 1 | Re-execute the trapped I/O instruction |

## Verification
The hardest case to reach from the ports is the one-deep latch. The bench pulses `smi_req` twice inside a handler and drives the resume through. It then shows that exactly one further session starts at the next boundary and that no third one follows. The drain gate is reached by releasing the store conditions one at a time. The last write is kept open until `brdy` comes back. Each shutdown cause gets its own session, and each ends with an NMI exit. A reset is applied mid-handler to show that it ends the session.

// File: rtl/smm_pkg.sv
`timescale 1ns/1ps
package smm_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_DRAIN, ST_SAVE, ST_HANDLER, ST_RESTORE, ST_SHUT
  } smm_state_e;

  localparam logic [1:0] MODE_REAL = 2'd0;
endpackage

// File: rtl/smm_event_arb.sv
`timescale 1ns/1ps
module smm_event_arb (
  input  logic en,
  input  logic brk,
  input  logic boundary,
  input  logic smi_any,
  input  logic dbg,
  input  logic irq,
  input  logic rsm,
  output logic take_smi,
  output logic take_dbg,
  output logic take_irq,
  output logic inv_op
);
  logic window;

  always_comb begin
    window   = en & brk;
    take_smi = window & smi_any;
    take_dbg = window & ~smi_any & dbg;
    take_irq = window & ~smi_any & ~dbg & irq;
    inv_op   = en & boundary & rsm & ~take_smi;
  end
endmodule

// File: rtl/smm_pend_latch.sv
`timescale 1ns/1ps
module smm_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic consume,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (consume)  q_d = 1'b0;
    else if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R4: a held request survives extra arrivals until it is consumed
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q && !consume |=> q);
endmodule

// File: rtl/smm_state_check.sv
`timescale 1ns/1ps
module smm_state_check #(
  parameter int BASE_W      = 32,
  parameter int ALIGN_BYTES = 32768
) (
  input  logic [BASE_W-1:0] base,
  input  logic              pg,
  input  logic              pe,
  input  logic              nw,
  input  logic              cd,
  output logic              bad
);
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);

  logic misaligned, cr0_illegal;

  always_comb begin
    misaligned  = |base[ALIGN_LSB-1:0];
    cr0_illegal = (pg & ~pe) | (nw & ~cd);
    bad         = misaligned | cr0_illegal;
  end
endmodule

// File: rtl/smm_sequencer.sv
`timescale 1ns/1ps
module smm_sequencer import smm_pkg::*; #(
  parameter int              BASE_W      = 32,
  parameter int              ALIGN_BYTES = 32768,
  parameter logic [BASE_W-1:0] BASE_RESET = 32'h0003_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_boundary,
  input  logic              cpu_halted,
  input  logic [1:0]        cur_mode,
  input  logic              smi_req,
  input  logic              dbg_req,
  input  logic              ext_irq_req,
  input  logic              nmi,
  input  logic              rsm_exec,
  input  logic              stores_pending,
  input  logic              wbuf_empty,
  input  logic              wr_inflight,
  input  logic              rdy,
  input  logic              brdy,
  input  logic              save_done,
  input  logic              restore_done,
  input  logic [BASE_W-1:0] rs_base,
  input  logic              rs_pg,
  input  logic              rs_pe,
  input  logic              rs_nw,
  input  logic              rs_cd,
  input  logic              rs_halt_slot,
  input  logic              rs_io_slot,
  output logic              take_smi,
  output logic              take_dbg,
  output logic              take_irq,
  output logic              invalid_opcode,
  output logic              irq_block,
  output logic              smiact,
  output logic              save_req,
  output logic              restore_req,
  output logic              smi_pending,
  output logic [BASE_W-1:0] smm_base,
  output logic              shutdown,
  output logic              shutdown_cycle,
  output logic              resume_valid,
  output logic [1:0]        resume_mode,
  output logic              redo_halt,
  output logic              redo_io
);
  smm_state_e state_q, state_d;
  logic              drained, in_run, bad_state;
  logic              ld_entry, ld_resume, fail_resume;
  logic [1:0]        mode_saved_q, resume_mode_q;
  logic              halt_saved_q;
  logic [BASE_W-1:0] base_q;
  logic              resume_q, redo_h_q, redo_io_q, shutcyc_q;

  assign in_run  = (state_q == ST_RUN);
  assign drained = ~stores_pending & wbuf_empty & (~wr_inflight | rdy | brdy);

  smm_event_arb u_arb (
    .en       (in_run),
    .brk      (insn_boundary | cpu_halted),
    .boundary (insn_boundary),
    .smi_any  (smi_req | smi_pending),
    .dbg      (dbg_req),
    .irq      (ext_irq_req),
    .rsm      (rsm_exec),
    .take_smi (take_smi),
    .take_dbg (take_dbg),
    .take_irq (take_irq),
    .inv_op   (invalid_opcode)
  );

  smm_pend_latch u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (smi_req & ~take_smi),
    .consume (take_smi),
    .q       (smi_pending)
  );

  smm_state_check #(.BASE_W(BASE_W), .ALIGN_BYTES(ALIGN_BYTES)) u_chk (
    .base (rs_base),
    .pg   (rs_pg),
    .pe   (rs_pe),
    .nw   (rs_nw),
    .cd   (rs_cd),
    .bad  (bad_state)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (take_smi)                  state_d = ST_DRAIN;
      ST_DRAIN:   if (drained)                   state_d = ST_SAVE;
      ST_SAVE:    if (save_done)                 state_d = ST_HANDLER;
      ST_HANDLER: if (insn_boundary && rsm_exec) state_d = ST_RESTORE;
      ST_RESTORE: if (restore_done)              state_d = bad_state ? ST_SHUT : ST_RUN;
      ST_SHUT:    if (nmi)                       state_d = ST_RUN;
      default:                                   state_d = ST_RUN;
    endcase
  end

  always_comb begin
    ld_entry    = take_smi;
    ld_resume   = (state_q == ST_RESTORE) & restore_done & ~bad_state;
    fail_resume = (state_q == ST_RESTORE) & restore_done & bad_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  // context captured at entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_saved_q <= MODE_REAL;
      halt_saved_q <= 1'b0;
    end else if (ld_entry) begin
      mode_saved_q <= cur_mode;
      halt_saved_q <= cpu_halted;
    end
  end

  // state loaded on a good resume
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q        <= BASE_RESET;
      resume_mode_q <= MODE_REAL;
    end else if (ld_resume) begin
      base_q        <= rs_base;
      resume_mode_q <= mode_saved_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_q  <= 1'b0;
      redo_h_q  <= 1'b0;
      redo_io_q <= 1'b0;
      shutcyc_q <= 1'b0;
    end else begin
      resume_q  <= ld_resume;
      redo_h_q  <= ld_resume & halt_saved_q & rs_halt_slot;
      redo_io_q <= ld_resume & rs_io_slot;
      shutcyc_q <= fail_resume;
    end
  end

  always_comb begin
    smiact         = (state_q == ST_SAVE) | (state_q == ST_HANDLER) | (state_q == ST_RESTORE);
    irq_block      = smiact | (state_q == ST_DRAIN);
    save_req       = (state_q == ST_SAVE);
    restore_req    = (state_q == ST_RESTORE);
    shutdown       = (state_q == ST_SHUT);
    shutdown_cycle = shutcyc_q;
    smm_base       = base_q;
    resume_valid   = resume_q;
    resume_mode    = resume_mode_q;
    redo_halt      = redo_h_q;
    redo_io        = redo_io_q;
  end

  // R1: an SMI at a RUN boundary wins over the other requests
  p_prio_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) && (insn_boundary || cpu_halted) && smi_req
      |-> take_smi && !take_dbg && !take_irq);

  // R2: SMM activity starts only after the store path is empty
  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smiact) |-> $past(!stores_pending && wbuf_empty && (!wr_inflight || rdy || brdy)));

  // R3: no ordinary interrupt is taken in SMM
  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smiact |-> irq_block && !take_dbg && !take_irq);

  // R5: an invalid resume leaves the mode untouched
  p_invop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_opcode |=> !smiact && !shutdown);

  // R6: shutdown follows only a completed restore
  p_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> $past(restore_req && restore_done));

  // R7: only NMI leaves shutdown
  p_shuthold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown && !nmi |=> shutdown);

  // R8: halt restart only with a resume
  p_redoh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redo_halt |-> resume_valid);

  // R9: I/O restart only with a resume
  p_redoio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redo_io |-> resume_valid);

  // R10: the base moves only on a good resume
  p_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(smm_base) |-> resume_valid);

  // R12: the save request is held until done
  p_save_r12: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && !save_done |=> save_req);

  // R13: SMM stays active until the restore completes
  p_act_r13: assert property (@(posedge clk) disable iff (!rst_n)
    smiact && !(restore_req && restore_done) |=> smiact);
endmodule

// File: tb/smm_sequencer_test.sv
`timescale 1ns/1ps
module smm_sequencer_test;
  localparam logic [31:0] BASE_DEF = 32'h0003_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic insn_boundary, cpu_halted, smi_req, dbg_req, ext_irq_req, nmi, rsm_exec;
  logic [1:0] cur_mode;
  logic stores_pending, wbuf_empty, wr_inflight, rdy, brdy, save_done, restore_done;
  logic [31:0] rs_base;
  logic rs_pg, rs_pe, rs_nw, rs_cd, rs_halt_slot, rs_io_slot;
  logic take_smi, take_dbg, take_irq, invalid_opcode, irq_block, smiact, save_req, restore_req;
  logic smi_pending, shutdown, shutdown_cycle, resume_valid, redo_halt, redo_io;
  logic [31:0] smm_base;
  logic [1:0] resume_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  smm_sequencer uut (.*);

  // behavioural reference: 0 run, 1 drain, 2 save, 3 handler, 4 restore, 5 shutdown
  int   m_ph;
  bit   m_pend, m_halt_at, m_resp, m_rh, m_rio, m_shc;
  int   m_mode_at, m_mode_out;
  logic [31:0] m_base;

  function automatic bit m_bad();
    return (rs_base[14:0] != 0) || (rs_pg && !rs_pe) || (rs_nw && !rs_cd);
  endfunction

  function automatic bit m_tk();
    return m_ph == 0 && (insn_boundary || cpu_halted) && (smi_req || m_pend);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pend = 0; m_base = BASE_DEF; m_mode_out = 0; m_mode_at = 0;
      m_halt_at = 0; m_resp = 0; m_rh = 0; m_rio = 0; m_shc = 0;
    end else begin
      bit tk;
      tk = m_tk();
      m_resp = 0; m_rh = 0; m_rio = 0; m_shc = 0;
      if (tk) m_pend = 0;
      else if (smi_req) m_pend = 1;
      case (m_ph)
        0: if (tk) begin m_ph = 1; m_mode_at = cur_mode; m_halt_at = cpu_halted; end
        1: if (!stores_pending && wbuf_empty && (!wr_inflight || rdy || brdy)) m_ph = 2;
        2: if (save_done) m_ph = 3;
        3: if (insn_boundary && rsm_exec) m_ph = 4;
        4: if (restore_done) begin
             if (m_bad()) begin m_ph = 5; m_shc = 1; end
             else begin
               m_ph = 0; m_base = rs_base; m_mode_out = m_mode_at; m_resp = 1;
               m_rh = m_halt_at && rs_halt_slot; m_rio = rs_io_slot;
             end
           end
        default: if (nmi) m_ph = 0;
      endcase
    end
  end

  task automatic cmp(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit tk, brk;
    tk  = m_tk();
    brk = m_ph == 0 && (insn_boundary || cpu_halted);
    cmp("R1", "take_smi", take_smi, tk);
    cmp("R1", "take_dbg", take_dbg, brk && !tk && dbg_req);
    cmp("R1", "take_irq", take_irq, brk && !tk && !dbg_req && ext_irq_req);
    cmp("R5", "invalid_opcode", invalid_opcode, m_ph == 0 && insn_boundary && rsm_exec && !tk);
    cmp("R3", "irq_block", irq_block, m_ph >= 1 && m_ph <= 4);
    cmp("R2", "smiact", smiact, m_ph >= 2 && m_ph <= 4);
    cmp("R12", "save_req", save_req, m_ph == 2);
    cmp("R12", "restore_req", restore_req, m_ph == 4);
    cmp("R4", "smi_pending", smi_pending, m_pend);
    cmp("R10", "smm_base", smm_base, m_base);
    cmp("R6", "shutdown", shutdown, m_ph == 5);
    cmp("R7", "shutdown_cycle", shutdown_cycle, m_shc);
    cmp("R13", "resume_valid", resume_valid, m_resp);
    cmp("R13", "resume_mode", resume_mode, m_mode_out);
    cmp("R8", "redo_halt", redo_halt, m_rh);
    cmp("R9", "redo_io", redo_io, m_rio);
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic enter_smm(input logic [1:0] mode, input logic halted);
    cur_mode = mode; cpu_halted = halted; smi_req = 1; insn_boundary = !halted;
    tick();
    smi_req = 0; insn_boundary = 0; cpu_halted = 0;
    tick(); tick();
    save_done = 1; tick(); save_done = 0;
  endtask

  task automatic leave_smm(input logic [31:0] b, input logic pg, pe, nw, cd, hs, io);
    insn_boundary = 1; rsm_exec = 1; tick();
    insn_boundary = 0; rsm_exec = 0; tick();
    rs_base = b; rs_pg = pg; rs_pe = pe; rs_nw = nw; rs_cd = cd;
    rs_halt_slot = hs; rs_io_slot = io; restore_done = 1; tick();
    restore_done = 0; tick();
  endtask

  task automatic nmi_exit();
    tick(); nmi = 1; tick(); nmi = 0; tick();
  endtask

  task automatic reset_checks();
    @(negedge clk);
    cmp("R11", "reset smm_base", smm_base, BASE_DEF);
    cmp("R11", "reset smi_pending", smi_pending, 0);
    cmp("R11", "reset smiact", smiact, 0);
    cmp("R11", "reset resume_mode", resume_mode, 0);
    cmp("R11", "reset shutdown", shutdown, 0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; insn_boundary = 0; cpu_halted = 0; cur_mode = 0; smi_req = 0;
    dbg_req = 0; ext_irq_req = 0; nmi = 0; rsm_exec = 0; stores_pending = 0;
    wbuf_empty = 1; wr_inflight = 0; rdy = 0; brdy = 0; save_done = 0; restore_done = 0;
    rs_base = 0; rs_pg = 0; rs_pe = 0; rs_nw = 0; rs_cd = 0; rs_halt_slot = 0; rs_io_slot = 0;
    repeat (3) tick();
    rst_n = 1; tick();
    reset_checks();

    // R1: debug alone, interrupt alone, both together
    insn_boundary = 1; dbg_req = 1; tick();
    dbg_req = 0; ext_irq_req = 1; tick();
    dbg_req = 1; tick();
    insn_boundary = 0; dbg_req = 0; ext_irq_req = 0; tick();

    // R1/R2: all three at once, store path busy, halted core in protected mode
    stores_pending = 1; cur_mode = 1; cpu_halted = 1;
    smi_req = 1; dbg_req = 1; ext_irq_req = 1; tick();
    smi_req = 0; dbg_req = 0; ext_irq_req = 0; cpu_halted = 0;
    repeat (3) tick();
    stores_pending = 0; wbuf_empty = 0; repeat (2) tick();
    wbuf_empty = 1; wr_inflight = 1; repeat (2) tick();
    @(negedge clk) cmp("R2", "no smiact before last write", smiact, 0);
    tick();
    brdy = 1; tick();
    brdy = 0; wr_inflight = 0;
    repeat (3) tick();
    save_done = 1; tick(); save_done = 0;

    // R3/R4: requests inside the handler
    insn_boundary = 1; dbg_req = 1; ext_irq_req = 1; tick();
    insn_boundary = 0; dbg_req = 0; ext_irq_req = 0;
    smi_req = 1; tick(); smi_req = 0; tick();
    smi_req = 1; tick(); smi_req = 0; tick();
    @(negedge clk) cmp("R4", "one held request", smi_pending, 1);
    tick();

    // R8/R9/R10/R13: good resume with both restart slots set
    leave_smm(32'h0004_8000, 0, 1, 0, 0, 1, 1);
    @(negedge clk) cmp("R10", "relocated base", smm_base, 32'h0004_8000);
    cmp("R13", "returned mode", resume_mode, 1);
    tick();

    // R4: replay of the held request, no third session
    cur_mode = 2; insn_boundary = 1; tick(); insn_boundary = 0;
    tick(); tick(); save_done = 1; tick(); save_done = 0;
    leave_smm(32'h0005_0000, 1, 1, 1, 1, 0, 0);
    insn_boundary = 1; tick(); insn_boundary = 0;
    @(negedge clk) cmp("R4", "no third session", smiact, 0);
    tick();

    // R5: resume outside SMM
    insn_boundary = 1; rsm_exec = 1;
    @(negedge clk) cmp("R5", "invalid strobe", invalid_opcode, 1);
    tick(); insn_boundary = 0; rsm_exec = 0; tick();

    // R6/R7: misaligned base
    enter_smm(0, 1);
    leave_smm(32'h0005_0100, 0, 1, 0, 1, 1, 1);
    @(negedge clk) cmp("R6", "shutdown on misaligned base", shutdown, 1);
    cmp("R10", "base kept on failure", smm_base, 32'h0005_0000);
    insn_boundary = 1; dbg_req = 1; smi_req = 1; tick();
    insn_boundary = 0; dbg_req = 0; smi_req = 0; tick();
    nmi_exit();
    insn_boundary = 1; tick(); insn_boundary = 0;
    tick(); tick(); save_done = 1; tick(); save_done = 0;
    leave_smm(32'h0006_0000, 1, 0, 0, 1, 0, 0);
    nmi_exit();

    // R6: cache bits forbidden pair
    enter_smm(1, 0);
    leave_smm(32'h0006_0000, 0, 1, 1, 0, 0, 1);
    nmi_exit();

    // R8: halted entry with the slot cleared; R9 slot set
    enter_smm(2, 1);
    leave_smm(32'h0007_8000, 0, 0, 0, 0, 0, 1);
    tick();

    // R11: reset in the middle of a handler
    enter_smm(1, 0);
    rst_n = 0; tick(); rst_n = 1; tick();
    reset_checks();
    repeat (3) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule